// File: doc/BRIEF.md
# Conflict-Address Buffer for False-Conflict Masking

This block sits next to a signature-based eager conflict checker in a transactional-memory core. Signatures hash addresses into bit arrays, so two unrelated cache blocks can alias and produce a conflict that is not real. The buffer remembers, for the lifetime of a software thread, the few cache-block addresses that have already triggered a signature conflict. For each remembered address it keeps two flags saying whether the running transaction may have read or written that block.

When a remote transactional request looks up an address the buffer holds, and the flags prove that the local transaction cannot conflict with it, the block raises `mask_nack` in the same cycle and the NACK that the signatures would have sent is cancelled. The block can only remove a NACK, never add one. A remote request that the signatures flag as a conflict, and whose address is not yet held, claims an entry: a free one if any exists, otherwise the least recently used. Its flags start as a copy of the two signature bits for that address.

Flags are cleared whenever the transaction commits or aborts. Entries themselves survive until a new thread starts or the core switches threads.

Top module: `cab_mask`

## Requirements
- R1: After reset, after `thread_start` and after `thread_switch`, no entry is held, so no request is masked until a new entry has been captured.
- R2: A remote request (`req_valid`=1) hits when a held entry has the same `req_addr`. `mask_nack` is combinational in the lookup cycle, uses the state held before that clock edge, and is 0 whenever `req_valid` is 0.
- R3: A hit on an entry whose read flag and write flag are both 0 asserts `mask_nack` for remote reads (`req_is_write`=0) and for remote writes (`req_is_write`=1).
- R4: A remote read that hits an entry whose write flag is 0 asserts `mask_nack` even if the read flag is 1.
- R5: `mask_nack` stays 0 on a miss, on a hit whose write flag is 1, and on a remote write that hits an entry whose read flag is 1.
- R6: `nack_out` = `req_valid` AND `sig_conflict` AND NOT `mask_nack`. It is never 1 unless `sig_conflict` is 1.
- R7: A request with `req_valid`=1 and `sig_conflict`=1 that misses allocates an entry for `req_addr`. Its read flag is loaded from `sig_rd_bit` and its write flag from `sig_wr_bit`, and the entry is visible from the next cycle. An address is never held twice, and a new entry is not matched in the cycle that creates it.
- R8: Allocation takes a free entry if one exists. Otherwise it replaces the least recently used entry. Recency is refreshed by a local-access hit and then by a remote hit or allocation in the same cycle, so the remote one ends up most recent. Recency is refreshed before the victim is chosen.
- R9: A local access (`loc_valid`=1) that hits a held entry sets that entry's write flag (`loc_is_write`=1) or read flag (`loc_is_write`=0) from the next cycle.
- R10: `txn_end` clears every read and write flag at the clock edge, including flags being set or loaded in that same cycle. Held entries stay held.
- R11: A thread clear (`thread_start` or `thread_switch`) takes priority over every allocation, flag update and `txn_end` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Remote transactional request present |
| req_addr | input | ADDR_W | Cache-block address of the remote request |
| req_is_write | input | 1 | 1 = remote write, 0 = remote read |
| sig_conflict | input | 1 | Signature checker declares a conflict for this request |
| sig_rd_bit | input | 1 | Read-signature bit for `req_addr` |
| sig_wr_bit | input | 1 | Write-signature bit for `req_addr` |
| loc_valid | input | 1 | Local transactional access present |
| loc_addr | input | ADDR_W | Cache-block address of the local access |
| loc_is_write | input | 1 | 1 = local write, 0 = local read |
| txn_end | input | 1 | Commit or abort strobe of the local transaction |
| thread_start | input | 1 | New thread begins on this core |
| thread_switch | input | 1 | Core switches to another thread |
| mask_nack | output | 1 | Cancel the signature NACK for this request |
| nack_out | output | 1 | Resulting NACK after masking |

## Verification
A flag left set when it should be clear costs only performance: a mask is lost and a NACK is sent that could have been cancelled. A flag left clear when it should be set, or an address held twice, is a correctness fault, because it lets `nack_out` fall while a real conflict exists. Both show on the very next remote request to that address. A wrong recency order stays hidden until the buffer is full and a miss evicts the wrong entry. It then appears as a mask where the reference expects a miss, or the reverse, on a later request. The bench therefore drives a small address pool, so that fills, evictions and flag changes keep occurring, and it compares both outputs with a queue-based model every cycle.

// File: rtl/cab_pkg.sv
package cab_pkg;

  // The buffer can prove no conflict when the local transaction never wrote
  // the block, and either never read it or the remote side only reads.
  function automatic logic may_mask(input logic rd_flag, input logic wr_flag,
                                    input logic remote_write);
    return !wr_flag && (!rd_flag || !remote_write);
  endfunction

  function automatic int age_width(input int entries);
    return (entries > 1) ? $clog2(entries) : 1;
  endfunction

endpackage

// File: rtl/cab_entry_bank.sv
module cab_entry_bank #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               txn_end,
  input  logic [ENTRIES-1:0] alloc_vec,
  input  logic               seed_rd,
  input  logic               seed_wr,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               loc_valid,
  input  logic [ADDR_W-1:0]  loc_addr,
  input  logic               loc_is_write,
  output logic [ENTRIES-1:0] req_hit_vec,
  output logic [ENTRIES-1:0] loc_hit_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] rd_vec,
  output logic [ENTRIES-1:0] wr_vec
);

  logic [ADDR_W-1:0] tag_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
        tag_q[i]     <= '0;
        rd_vec[i]    <= 1'b0;
        wr_vec[i]    <= 1'b0;
      end else if (clear) begin
        valid_vec[i] <= 1'b0;
        rd_vec[i]    <= 1'b0;
        wr_vec[i]    <= 1'b0;
      end else begin
        if (alloc_vec[i]) begin
          valid_vec[i] <= 1'b1;
          tag_q[i]     <= req_addr;
        end
        if (txn_end) begin
          rd_vec[i] <= 1'b0;
          wr_vec[i] <= 1'b0;
        end else if (alloc_vec[i]) begin
          rd_vec[i] <= seed_rd;
          wr_vec[i] <= seed_wr;
        end else if (loc_hit_vec[i]) begin
          if (loc_is_write) wr_vec[i] <= 1'b1;
          else              rd_vec[i] <= 1'b1;
        end
      end
    end

    assign req_hit_vec[i] = req_valid && valid_vec[i] && (tag_q[i] == req_addr);
    assign loc_hit_vec[i] = loc_valid && valid_vec[i] && (tag_q[i] == loc_addr);
  end

  AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_hit_vec)); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (valid_vec == '0)); // R1
  AST_TXN_END_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |=> (rd_vec == '0) && (wr_vec == '0)); // R10
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ($countones(valid_vec) >= $past($countones(valid_vec)))); // R10
  AST_LOC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !txn_end && loc_valid && loc_is_write && (|loc_hit_vec))
      |=> (|(wr_vec & $past(loc_hit_vec)))); // R9

endmodule

// File: rtl/cab_lru.sv
module cab_lru #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] loc_touch_vec,
  input  logic [ENTRIES-1:0] rem_touch_vec,
  output logic [ENTRIES-1:0] victim_vec
);
  import cab_pkg::*;

  localparam int AGE_W = age_width(ENTRIES);
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  typedef logic [ENTRIES-1:0][AGE_W-1:0] ages_t;

  ages_t age_q, age_mid, age_next;

  // Move the touched entry to age 0; valid entries younger than it grow older.
  function automatic ages_t touch(input ages_t a, input logic [ENTRIES-1:0] v,
                                  input logic [ENTRIES-1:0] t);
    ages_t r;
    logic [AGE_W-1:0] ref_age;
    ref_age = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (t[i]) ref_age = ref_age | a[i];
    for (int j = 0; j < ENTRIES; j++) begin
      if (t[j])                                  r[j] = '0;
      else if ((|t) && v[j] && (a[j] < ref_age)) r[j] = AGE_W'(a[j] + 1'b1);
      else                                       r[j] = a[j];
    end
    return r;
  endfunction

  always_comb begin
    age_mid = touch(age_q, valid_vec, loc_touch_vec);
    for (int k = 0; k < ENTRIES; k++)
      victim_vec[k] = valid_vec[k] && (age_mid[k] == OLDEST);
  end

  always_comb age_next = touch(age_mid, valid_vec, rem_touch_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     age_q <= {ENTRIES{OLDEST}};
    else if (clear) age_q <= {ENTRIES{OLDEST}};
    else            age_q <= age_next;
  end

  AST_VICTIM_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (&valid_vec) |-> ($countones(victim_vec) == 1)); // R8

endmodule

// File: rtl/cab_alloc_pick.sv
module cab_alloc_pick #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               want,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] victim_vec,
  output logic [ENTRIES-1:0] alloc_vec
);

  logic [ENTRIES-1:0] free_pick;
  logic               any_free;

  always_comb begin
    free_pick = '0;
    any_free  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_vec[i] && !any_free) begin
        free_pick[i] = 1'b1;
        any_free     = 1'b1;
      end
    end
    if (!want)        alloc_vec = '0;
    else if (any_free) alloc_vec = free_pick;
    else              alloc_vec = victim_vec;
  end

  AST_ALLOC_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    want |-> ($countones(alloc_vec) == 1)); // R8
  AST_ALLOC_PREFERS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (want && !(&valid_vec)) |-> ((alloc_vec & valid_vec) == '0)); // R8

endmodule

// File: rtl/cab_mask.sv
module cab_mask #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_write,
  input  logic              sig_conflict,
  input  logic              sig_rd_bit,
  input  logic              sig_wr_bit,
  input  logic              loc_valid,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              loc_is_write,
  input  logic              txn_end,
  input  logic              thread_start,
  input  logic              thread_switch,
  output logic              mask_nack,
  output logic              nack_out
);
  import cab_pkg::*;

  logic               thread_clear;
  logic               alloc_want;
  logic [ENTRIES-1:0] req_hit_vec, loc_hit_vec, valid_vec, rd_vec, wr_vec;
  logic [ENTRIES-1:0] victim_vec, alloc_vec, rem_touch_vec, mask_vec;

  assign thread_clear  = thread_start || thread_switch;
  assign alloc_want    = req_valid && sig_conflict && !(|req_hit_vec) && !thread_clear;
  assign rem_touch_vec = req_hit_vec | alloc_vec;

  cab_entry_bank #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear        (thread_clear),
    .txn_end      (txn_end),
    .alloc_vec    (alloc_vec),
    .seed_rd      (sig_rd_bit),
    .seed_wr      (sig_wr_bit),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .loc_valid    (loc_valid),
    .loc_addr     (loc_addr),
    .loc_is_write (loc_is_write),
    .req_hit_vec  (req_hit_vec),
    .loc_hit_vec  (loc_hit_vec),
    .valid_vec    (valid_vec),
    .rd_vec       (rd_vec),
    .wr_vec       (wr_vec)
  );

  cab_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (thread_clear),
    .valid_vec     (valid_vec),
    .loc_touch_vec (loc_hit_vec),
    .rem_touch_vec (rem_touch_vec),
    .victim_vec    (victim_vec)
  );

  cab_alloc_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .want       (alloc_want),
    .valid_vec  (valid_vec),
    .victim_vec (victim_vec),
    .alloc_vec  (alloc_vec)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rule
    assign mask_vec[i] = req_hit_vec[i] && may_mask(rd_vec[i], wr_vec[i], req_is_write);
  end

  assign mask_nack = |mask_vec;
  assign nack_out  = req_valid && sig_conflict && !mask_nack;

  AST_MASK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mask_nack |-> (req_valid && (|req_hit_vec))); // R2
  AST_NACK_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    nack_out |-> sig_conflict); // R6
  AST_WRITTEN_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_hit_vec & wr_vec)) |-> !mask_nack); // R5
  AST_ALLOC_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_vec) |-> (sig_conflict && !mask_nack && !thread_clear)); // R7
  AST_CLEAR_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    thread_clear |-> (alloc_vec == '0)); // R11

endmodule

// File: tb/cab_mask_bench.sv
module cab_mask_bench;
  localparam int N  = 4;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_is_write = 0, sig_conflict = 0, sig_rd_bit = 0, sig_wr_bit = 0;
  logic loc_valid = 0, loc_is_write = 0, txn_end = 0, thread_start = 0, thread_switch = 0;
  logic [AW-1:0] req_addr = '0, loc_addr = '0;
  logic mask_nack, nack_out;

  always #2 clk = ~clk;  // 250 MHz

  cab_mask #(.ENTRIES(N), .ADDR_W(AW)) u_cab_mask (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_write(req_is_write), .sig_conflict(sig_conflict), .sig_rd_bit(sig_rd_bit),
    .sig_wr_bit(sig_wr_bit), .loc_valid(loc_valid), .loc_addr(loc_addr),
    .loc_is_write(loc_is_write), .txn_end(txn_end), .thread_start(thread_start),
    .thread_switch(thread_switch), .mask_nack(mask_nack), .nack_out(nack_out)
  );

  typedef struct { int addr; bit rd; bit wr; } ent_t;
  ent_t model_q[$];   // front = most recently used
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  function automatic int find(input int a);
    foreach (model_q[i]) if (model_q[i].addr == a) return i;
    return -1;
  endfunction

  function automatic void to_front(input int i);
    ent_t e;
    e = model_q[i];
    model_q.delete(i);
    model_q.push_front(e);
  endfunction

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input bit rv, input int ra, input bit rw,
                     input bit sc, input bit srd, input bit swr,
                     input bit lv, input int la, input bit lw,
                     input bit te, input bit ts, input bit tsw);
    int  h, lh;
    bit  em, en;
    @(negedge clk);
    req_valid = rv; req_addr = AW'(ra); req_is_write = rw;
    sig_conflict = sc; sig_rd_bit = srd; sig_wr_bit = swr;
    loc_valid = lv; loc_addr = AW'(la); loc_is_write = lw;
    txn_end = te; thread_start = ts; thread_switch = tsw;
    #1;
    h  = rv ? find(ra) : -1;
    em = (h >= 0) && !model_q[h].wr && (!rw || !model_q[h].rd);
    en = rv && sc && !em;
    check(tag, "mask_nack", mask_nack, em);
    check(tag, "nack_out R6", nack_out, en);
    if (ts || tsw) begin
      model_q.delete();
    end else begin
      lh = lv ? find(la) : -1;
      if (lh >= 0) begin
        if (lw) model_q[lh].wr = 1; else model_q[lh].rd = 1;
        to_front(lh);
      end
      if (rv) begin
        h = find(ra);
        if (h >= 0) to_front(h);
        else if (sc) begin
          if (model_q.size() == N) void'(model_q.pop_back());
          model_q.push_front('{ra, srd, swr});
        end
      end
      if (te) foreach (model_q[i]) begin model_q[i].rd = 0; model_q[i].wr = 0; end
    end
  endtask

  task automatic idle();
    cyc("idle", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: empty after reset, a conflict request is never masked
    cyc("R1", 1, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);  // also allocates 10 (R7)
    // R3: hit with both flags clear, read and write
    cyc("R3", 1, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3", 1, 10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: local read sets read flag; R4 remote read still masked; R5 remote write not
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 10, 0, 0, 0, 0);
    cyc("R4", 1, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R5", 1, 10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: local write; R5 any request no longer masked
    cyc("R9", 0, 0, 0, 0, 0, 0, 1, 10, 1, 0, 0, 0);
    cyc("R5", 1, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10: txn_end with a same-cycle local write; flags cleared, entry kept
    cyc("R10", 0, 0, 0, 0, 0, 0, 1, 10, 1, 1, 0, 0);
    cyc("R10", 1, 10, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: seeded flags; write bit seeded -> no mask, read bit seeded -> read masked
    cyc("R7", 1, 20, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1, 20, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1, 21, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1, 21, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7", 1, 21, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R8: buffer holds 10,20,21; fill with 22, then 23 evicts LRU
    cyc("R8", 1, 22, 0, 1, 0, 0, 1, 10, 0, 0, 0, 0);
    cyc("R8", 1, 23, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 20, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8", 1, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2: no request -> no mask; no conflict -> no allocation
    cyc("R2", 0, 10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 30, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2", 1, 30, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R11: thread switch wins over a same-cycle allocation
    cyc("R11", 1, 40, 0, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    cyc("R11", 1, 40, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc("R1", 1, 40, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle();
    // R8/R5/R9/R10: random traffic on a small pool to exercise eviction order
    for (int k = 0; k < 4000; k++) begin
      bit clr;
      clr = ($urandom_range(99) == 0);
      cyc("R8", $urandom_range(3) != 0, $urandom_range(5), $urandom_range(1),
          $urandom_range(2) != 0, $urandom_range(1), $urandom_range(3) == 0,
          $urandom_range(1), $urandom_range(5), $urandom_range(1),
          $urandom_range(15) == 0, clr && $urandom_range(1), clr);
    end
    done = 1;
    summary();
  end
endmodule